// File: doc/BRIEF.md
# Interrupt Vector Table Register File

This block stores the per-vector message table used for message-signalled interrupts. Each vector owns a 16-byte slot holding a 64-bit message address (a low and a high word), a 32-bit message data word and a 32-bit control word. Bit 0 of the control word masks the vector. Software reaches the table through a plain register bus. Each access carries an offset, a byte count of 4 or 8, write data and a write flag. Reads return little-endian data one cycle later.

A second read port, indexed directly by vector number, lets a delivery engine fetch the address, data and mask bit it needs for a given vector. The block also flags the cases where software lifts a vector's mask. When a write clears control bit 0 that was set, the block emits a one-cycle pulse with the vector number, so pending work for that vector can be delivered.

Top module: `irq_vector_table`

## Requirements
- R1: The slot number is the offset divided by 16. A 4-byte access selects its word by offset bits [3:2]: 0x0 is address-low, 0x4 is address-high, 0x8 is message data and 0xC is control. Read data sits in bits [31:0], and bits [63:32] read as zero.
- R2: An 8-byte access at slot offset 0x0 carries address-high in bits [63:32] and address-low in bits [31:0], for both reads and writes.
- R3: An 8-byte access at slot offset 0x8 carries the control word in bits [63:32] and message data in bits [31:0], for both reads and writes.
- R4: A legal-size read whose slot number is not below NUM_VECTORS returns all ones at the access width. A 4-byte read gives 0x00000000_FFFFFFFF and an 8-byte read gives all 64 bits set. A write to such a slot changes no entry and raises no pulse.
- R5: After reset every entry has zero address words and zero data, and its control word is 0x00000001, so the vector is masked.
- R6: Only byte counts 4 and 8 are legal. A read with any other count returns zero, and a write with any other count is dropped. A 4-byte access with offset bits [1:0] non-zero is misaligned, and so is an 8-byte access with offset bits [2:0] non-zero. A misaligned read returns zero and a misaligned write is dropped.
- R7: busRvalid is high in exactly the cycle after each read request, and busRdata is valid in that cycle.
- R8: When a write changes control bit 0 of a slot from 1 to 0, unmaskPulse is high for one cycle, in the cycle after the write, and unmaskIdx carries the slot number.
- R9: A write that leaves the entry unchanged raises no pulse. A write that sets control bit 0 raises no pulse, and neither does a write that leaves it at 0.
- R10: One cycle after fetchIdx is applied, fetchAddr holds {address-high, address-low}, fetchData holds the message data and fetchMask holds control bit 0 of that vector. An index not below NUM_VECTORS gives zero address and data with fetchMask set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Access request, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | OFFS_W | Byte offset into the table |
| busBytes | input | 4 | Access size in bytes (4 or 8 legal) |
| busWdata | input | 64 | Write data, little-endian |
| busRdata | output | 64 | Read data, valid with busRvalid |
| busRvalid | output | 1 | Read data valid, one cycle after a read request |
| fetchIdx | input | IDX_W+1 | Vector number for the delivery read port |
| fetchAddr | output | 64 | Message address of the fetched vector |
| fetchData | output | 32 | Message data of the fetched vector |
| fetchMask | output | 1 | Mask bit of the fetched vector |
| unmaskPulse | output | 1 | One-cycle pulse when a vector's mask goes 1 to 0 |
| unmaskIdx | output | IDX_W | Vector number belonging to unmaskPulse |

## Verification
Register-bus reads answer in the cycle after the request edge. The driver pushes the expected word into a queue when it issues the read, and the monitor pops and compares on the falling edge where busRvalid is high. The unmask pulse also appears one edge after the write. The write task therefore compares unmaskPulse and unmaskIdx on the falling edge that follows the write, and this covers both the pulsing cases and the cases where no pulse is allowed. The fetch port is registered, so its outputs are sampled one falling edge after fetchIdx changes. Writes that must be ignored are checked by reading back the slot they would have touched.

// File: rtl/vtab_pkg.sv
package vtab_pkg;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_ONES  = 2'd1,
    RD_FIELD = 2'd2
  } rdKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [3:0] fieldWe;   // 0 addrLo, 1 addrHi, 2 msgData, 3 ctl
    logic       rdEn;
    rdKind_e    rdKind;
    logic       wide;      // 8-byte access
    logic       upperPair; // 8-byte access at slot offset 0x8
    logic [1:0] fieldSel;  // word select for 4-byte reads
  } strobes_t;

  typedef struct packed {
    logic [31:0] ctl;
    logic [31:0] msgData;
    logic [31:0] addrHi;
    logic [31:0] addrLo;
  } entry_t;

  localparam logic [31:0] CTL_RESET = 32'h0000_0001;

endpackage

// File: rtl/vtab_ctrl.sv
module vtab_ctrl
  import vtab_pkg::*;
#(
  parameter int NUM_VECTORS = 8,
  parameter int OFFS_W      = 16,
  parameter int IDX_W       = 3
) (
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [OFFS_W-1:0] busAddr,
  input  logic [3:0]        busBytes,
  output strobes_t          strb,
  output logic [IDX_W-1:0]  entryIdx
);
  localparam int SLOT_W = OFFS_W - 4;

  logic [SLOT_W-1:0] slot;
  logic              inRange;
  logic              isFour;
  logic              isEight;
  logic              aligned;
  logic              legalSize;

  assign slot      = busAddr[OFFS_W-1:4];
  assign inRange   = (32'(slot) < NUM_VECTORS);
  assign isFour    = (busBytes == 4'd4);
  assign isEight   = (busBytes == 4'd8);
  assign legalSize = isFour | isEight;
  assign aligned   = isEight ? (busAddr[2:0] == 3'd0) : (busAddr[1:0] == 2'd0);
  assign entryIdx  = IDX_W'(slot);

  always_comb begin
    strb           = '0;
    strb.rdKind    = RD_ZERO;
    strb.wide      = isEight;
    strb.upperPair = busAddr[3];
    strb.fieldSel  = busAddr[3:2];
    if (busReq && !busWrite) begin
      strb.rdEn = 1'b1;
      if (!legalSize)    strb.rdKind = RD_ZERO;
      else if (!inRange) strb.rdKind = RD_ONES;
      else if (!aligned) strb.rdKind = RD_ZERO;
      else               strb.rdKind = RD_FIELD;
    end
    if (busReq && busWrite && legalSize && inRange && aligned) begin
      if (isEight) strb.fieldWe = busAddr[3] ? 4'b1100 : 4'b0011;
      else         strb.fieldWe = 4'b0001 << busAddr[3:2];
    end
  end

endmodule

// File: rtl/vtab_datapath.sv
module vtab_datapath
  import vtab_pkg::*;
#(
  parameter int NUM_VECTORS = 8,
  parameter int IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [IDX_W-1:0] entryIdx,
  input  logic [63:0]      busWdata,
  output logic [63:0]      busRdata,
  output logic             busRvalid,
  input  logic [IDX_W:0]   fetchIdx,
  output logic [63:0]      fetchAddr,
  output logic [31:0]      fetchData,
  output logic             fetchMask,
  output logic             unmaskPulse,
  output logic [IDX_W-1:0] unmaskIdx
);
  entry_t      entryArr [NUM_VECTORS];
  entry_t      curEntry;
  logic [31:0] curWord  [4];
  logic [31:0] newWord  [4];
  logic        idxValid;
  logic        commit;
  logic        willUnmask;

  assign idxValid = (32'(entryIdx) < NUM_VECTORS);
  assign curEntry = idxValid ? entryArr[entryIdx] : '0;

  assign curWord[0] = curEntry.addrLo;
  assign curWord[1] = curEntry.addrHi;
  assign curWord[2] = curEntry.msgData;
  assign curWord[3] = curEntry.ctl;

  // lower lane feeds lo/data; upper lane feeds hi/ctl on 8-byte writes
  assign newWord[0] = busWdata[31:0];
  assign newWord[1] = strb.wide ? busWdata[63:32] : busWdata[31:0];
  assign newWord[2] = busWdata[31:0];
  assign newWord[3] = strb.wide ? busWdata[63:32] : busWdata[31:0];

  always_comb begin
    commit = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (strb.fieldWe[k] && (newWord[k] != curWord[k])) commit = 1'b1;
    end
  end

  assign willUnmask = commit && strb.fieldWe[3] && curWord[3][0] && !newWord[3][0];

  for (genvar v = 0; v < NUM_VECTORS; v++) begin : g_vec
    entry_t entryQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryQ <= '{ctl: CTL_RESET, msgData: 32'd0, addrHi: 32'd0, addrLo: 32'd0};
      end else if (commit && (32'(entryIdx) == v)) begin
        if (strb.fieldWe[0]) entryQ.addrLo  <= newWord[0];
        if (strb.fieldWe[1]) entryQ.addrHi  <= newWord[1];
        if (strb.fieldWe[2]) entryQ.msgData <= newWord[2];
        if (strb.fieldWe[3]) entryQ.ctl     <= newWord[3];
      end
    end
    assign entryArr[v] = entryQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unmaskPulse <= 1'b0;
      unmaskIdx   <= '0;
    end else begin
      unmaskPulse <= willUnmask;
      unmaskIdx   <= entryIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRvalid <= 1'b0;
      busRdata  <= '0;
    end else begin
      busRvalid <= strb.rdEn;
      if (strb.rdEn) begin
        unique case (strb.rdKind)
          RD_ONES:  busRdata <= strb.wide ? {64{1'b1}} : {32'd0, 32'hFFFF_FFFF};
          RD_FIELD: begin
            if (strb.wide)
              busRdata <= strb.upperPair ? {curWord[3], curWord[2]}
                                         : {curWord[1], curWord[0]};
            else
              busRdata <= {32'd0, curWord[strb.fieldSel]};
          end
          default:  busRdata <= '0;
        endcase
      end
    end
  end

  logic   fetchOk;
  entry_t fetchEntry;
  assign fetchOk    = (32'(fetchIdx) < NUM_VECTORS);
  assign fetchEntry = fetchOk ? entryArr[fetchIdx[IDX_W-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchAddr <= '0;
      fetchData <= '0;
      fetchMask <= 1'b1;
    end else begin
      fetchAddr <= {fetchEntry.addrHi, fetchEntry.addrLo};
      fetchData <= fetchEntry.msgData;
      fetchMask <= fetchOk ? fetchEntry.ctl[0] : 1'b1;
    end
  end

  // R9
  pulse_needs_ctl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    unmaskPulse |-> $past(strb.fieldWe[3]));

  // R8
  pulse_clears_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    unmaskPulse && (32'(unmaskIdx) == 32'(fetchIdx)) && $stable(fetchIdx) |=> !fetchMask);

endmodule

// File: rtl/irq_vector_table.sv
module irq_vector_table
  import vtab_pkg::*;
#(
  parameter int  NUM_VECTORS = 8,
  parameter int  OFFS_W      = 16,
  localparam int IDX_W       = (NUM_VECTORS > 1) ? $clog2(NUM_VECTORS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [OFFS_W-1:0] busAddr,
  input  logic [3:0]        busBytes,
  input  logic [63:0]       busWdata,
  output logic [63:0]       busRdata,
  output logic              busRvalid,
  input  logic [IDX_W:0]    fetchIdx,
  output logic [63:0]       fetchAddr,
  output logic [31:0]       fetchData,
  output logic              fetchMask,
  output logic              unmaskPulse,
  output logic [IDX_W-1:0]  unmaskIdx
);
  strobes_t         strb;
  logic [IDX_W-1:0] entryIdx;

  vtab_ctrl #(
    .NUM_VECTORS(NUM_VECTORS),
    .OFFS_W     (OFFS_W),
    .IDX_W      (IDX_W)
  ) ctrl_i (
    .busReq  (busReq),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busBytes(busBytes),
    .strb    (strb),
    .entryIdx(entryIdx)
  );

  vtab_datapath #(
    .NUM_VECTORS(NUM_VECTORS),
    .IDX_W      (IDX_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .entryIdx   (entryIdx),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .busRvalid  (busRvalid),
    .fetchIdx   (fetchIdx),
    .fetchAddr  (fetchAddr),
    .fetchData  (fetchData),
    .fetchMask  (fetchMask),
    .unmaskPulse(unmaskPulse),
    .unmaskIdx  (unmaskIdx)
  );

  // R7
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busWrite |=> busRvalid);

  // R7
  no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busReq && !busWrite) |=> !busRvalid);

  // R8
  pulse_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    unmaskPulse |-> $past(busReq && busWrite));

  // R4
  oor_wide_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busWrite && (busBytes == 4'd8) && (32'(busAddr[OFFS_W-1:4]) >= NUM_VECTORS)
    |=> (busRdata == {64{1'b1}}));

  // R10
  fetch_oor_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (32'(fetchIdx) >= NUM_VECTORS) |=> fetchMask);

endmodule

// File: tb/irq_vector_table_tb_top.sv
module irq_vector_table_tb_top;
  localparam int NV   = 8;
  localparam int OW   = 12;
  localparam int IW   = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          busReq;
  logic          busWrite;
  logic [OW-1:0] busAddr;
  logic [3:0]    busBytes;
  logic [63:0]   busWdata;
  logic [63:0]   busRdata;
  logic          busRvalid;
  logic [IW:0]   fetchIdx;
  logic [63:0]   fetchAddr;
  logic [31:0]   fetchData;
  logic          fetchMask;
  logic          unmaskPulse;
  logic [IW-1:0] unmaskIdx;

  int checks = 0;
  int fails  = 0;

  logic [63:0] expQ[$];
  string       tagQ[$];

  logic [31:0] mLo [NV];
  logic [31:0] mHi [NV];
  logic [31:0] mDat[NV];
  logic [31:0] mCtl[NV];

  always #10 clk = ~clk; // 50 MHz

  irq_vector_table #(.NUM_VECTORS(NV), .OFFS_W(OW)) dut_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busBytes(busBytes), .busWdata(busWdata),
    .busRdata(busRdata), .busRvalid(busRvalid), .fetchIdx(fetchIdx),
    .fetchAddr(fetchAddr), .fetchData(fetchData), .fetchMask(fetchMask),
    .unmaskPulse(unmaskPulse), .unmaskIdx(unmaskIdx)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
    end
  endtask

  function automatic bit legalHit(input logic [OW-1:0] a, input int nb);
    bit alignedOk;
    if (nb != 4 && nb != 8) return 0;
    if (int'(a >> 4) >= NV) return 0;
    alignedOk = (nb == 8) ? (a[2:0] == 0) : (a[1:0] == 0);
    return alignedOk;
  endfunction

  function automatic logic [63:0] modelRead(input logic [OW-1:0] a, input int nb);
    int s;
    s = int'(a >> 4);
    if (nb != 4 && nb != 8) return 64'd0;
    if (s >= NV) return (nb == 8) ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF;
    if (!legalHit(a, nb)) return 64'd0;
    if (nb == 8) return a[3] ? {mCtl[s], mDat[s]} : {mHi[s], mLo[s]};
    case (a[3:2])
      2'd0: return {32'd0, mLo[s]};
      2'd1: return {32'd0, mHi[s]};
      2'd2: return {32'd0, mDat[s]};
      default: return {32'd0, mCtl[s]};
    endcase
  endfunction

  task automatic doRead(input logic [OW-1:0] a, input int nb, input string req);
    @(negedge clk);
    busReq = 1; busWrite = 0; busAddr = a; busBytes = 4'(nb);
    expQ.push_back(modelRead(a, nb));
    tagQ.push_back(req);
    @(negedge clk);
    busReq = 0;
  endtask

  task automatic doWrite(input logic [OW-1:0] a, input int nb, input logic [63:0] d, input string req);
    int  s;
    bit  expPulse;
    logic [31:0] oldCtl;
    s = int'(a >> 4);
    expPulse = 0;
    if (legalHit(a, nb)) begin
      oldCtl = mCtl[s];
      if (nb == 8) begin
        if (a[3]) begin mDat[s] = d[31:0]; mCtl[s] = d[63:32]; end
        else      begin mLo[s]  = d[31:0]; mHi[s]  = d[63:32]; end
      end else begin
        case (a[3:2])
          2'd0: mLo[s]  = d[31:0];
          2'd1: mHi[s]  = d[31:0];
          2'd2: mDat[s] = d[31:0];
          default: mCtl[s] = d[31:0];
        endcase
      end
      expPulse = oldCtl[0] && !mCtl[s][0];
    end
    @(negedge clk);
    busReq = 1; busWrite = 1; busAddr = a; busBytes = 4'(nb); busWdata = d;
    @(negedge clk);
    busReq = 0; busWrite = 0;
    check(unmaskPulse == expPulse, req, 64'(unmaskPulse), 64'(expPulse));
    if (expPulse) check(unmaskIdx == IW'(s), req, 64'(unmaskIdx), 64'(s));
  endtask

  task automatic doFetch(input int idx, input string req);
    logic [63:0] eA;
    logic [31:0] eD;
    bit          eM;
    if (idx < NV) begin eA = {mHi[idx], mLo[idx]}; eD = mDat[idx]; eM = mCtl[idx][0]; end
    else begin eA = 0; eD = 0; eM = 1; end
    @(negedge clk);
    fetchIdx = (IW+1)'(idx);
    @(negedge clk);
    check(fetchAddr == eA, req, fetchAddr, eA);
    check(fetchData == eD, req, 64'(fetchData), 64'(eD));
    check(fetchMask == eM, req, 64'(fetchMask), 64'(eM));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && busRvalid) begin
      if (expQ.size() == 0) begin
        check(0, "R7 unexpected rvalid", 64'(busRvalid), 64'd0);
      end else begin
        logic [63:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(busRdata == e, t, busRdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      mLo[v] = 0; mHi[v] = 0; mDat[v] = 0; mCtl[v] = 32'h1;
    end
    rstN = 0; busReq = 0; busWrite = 0; busAddr = 0; busBytes = 4; busWdata = 0; fetchIdx = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(busRvalid == 0, "R7 idle after reset", 64'(busRvalid), 64'd0);
    check(unmaskPulse == 0, "R5 no pulse at reset", 64'(unmaskPulse), 64'd0);

    // R5 reset values
    doRead(12'h000, 4, "R5 lo reset");
    doRead(12'h00C, 4, "R5 ctl reset");
    doRead(12'h078, 8, "R5 slot7 ctl/data reset");
    doFetch(0, "R5 R10 fetch after reset");

    // R1 4-byte fields
    doWrite(12'h010, 4, 64'h0, "R1 no pulse lo");
    doWrite(12'h010, 4, 64'hFFFF_FFFF_1111_0000, "R1 wr lo");
    doWrite(12'h014, 4, 64'h2222_0001, "R1 wr hi");
    doWrite(12'h018, 4, 64'h3333_0002, "R1 wr data");
    doRead(12'h010, 4, "R1 rd lo");
    doRead(12'h014, 4, "R1 rd hi");
    doRead(12'h018, 4, "R1 rd data");
    doRead(12'h01C, 4, "R1 rd ctl");
    doRead(12'h010, 8, "R2 rd pair lo/hi");
    doRead(12'h018, 8, "R3 rd pair data/ctl");

    // R2 R3 8-byte writes
    doWrite(12'h030, 8, 64'hAAAA_0003_BBBB_0004, "R2 wr pair");
    doWrite(12'h038, 8, 64'h0000_0001_CCCC_0005, "R3 wr pair masked");
    doRead(12'h030, 4, "R2 lo lane");
    doRead(12'h034, 4, "R2 hi lane");
    doRead(12'h038, 4, "R3 data lane");
    doRead(12'h03C, 4, "R3 ctl lane");

    // R8 R9 unmask pulses
    doWrite(12'h038, 8, 64'h0000_0000_CCCC_0005, "R8 unmask via 8-byte");
    doWrite(12'h038, 8, 64'h0000_0000_CCCC_0005, "R9 identical rewrite");
    doWrite(12'h03C, 4, 64'h0, "R9 stays unmasked");
    doWrite(12'h03C, 4, 64'h1, "R9 mask set");
    doWrite(12'h07C, 4, 64'h0, "R8 unmask slot7 4-byte");
    doWrite(12'h03C, 4, 64'h0000_0006, "R8 unmask keeps other bits");
    doFetch(3, "R10 fetch slot3");
    doFetch(7, "R10 fetch slot7");
    doFetch(1, "R10 fetch slot1 masked");

    // R4 out of range
    doRead(12'h080, 4, "R4 oor 4-byte");
    doRead(12'h098, 8, "R4 oor 8-byte");
    doWrite(12'h080, 8, 64'h1234_5678_9ABC_DEF0, "R4 oor write no pulse");
    doWrite(12'h08C, 4, 64'h0, "R4 oor ctl write no pulse");
    doRead(12'h000, 8, "R4 slot0 untouched");
    doRead(12'h008, 8, "R4 slot0 ctl untouched");
    doFetch(9, "R10 fetch oor");

    // R6 illegal size and misalignment
    doRead(12'h012, 4, "R6 misaligned 4-byte read");
    doRead(12'h014, 8, "R6 misaligned 8-byte read");
    doRead(12'h010, 2, "R6 size 2 read");
    doWrite(12'h012, 4, 64'hDEAD, "R6 misaligned write");
    doWrite(12'h05C, 2, 64'h0, "R6 size 2 write to ctl");
    doWrite(12'h054, 8, 64'h0, "R6 misaligned 8-byte write");
    doRead(12'h010, 4, "R6 lo unchanged");
    doRead(12'h058, 8, "R6 slot5 ctl unchanged");
    doRead(12'h050, 8, "R6 slot5 addr unchanged");

    // R7 back-to-back reads then idle
    @(negedge clk);
    busReq = 1; busWrite = 0; busAddr = 12'h030; busBytes = 8;
    expQ.push_back(modelRead(12'h030, 8)); tagQ.push_back("R7 b2b first");
    @(negedge clk);
    busAddr = 12'h03C; busBytes = 4;
    expQ.push_back(modelRead(12'h03C, 4)); tagQ.push_back("R7 b2b second");
    @(negedge clk);
    busReq = 0;
    @(negedge clk);
    check(busRvalid == 0, "R7 rvalid drops", 64'(busRvalid), 64'd0);
    check(expQ.size() == 0, "R7 all reads answered", 64'(expQ.size()), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule